// File: doc/BRIEF.md
# Quarter-Pel Bicubic Luma Interpolator

This block computes one 8x8 block of motion-compensated luma samples at a fractional position. The horizontal and vertical offsets are each given in quarter-pel steps from 0 to 3. A one-bit rounding control is also taken. The caller pulses `start` with the two modes, the rounding bit and the put/average choice. The caller then streams an 11x11 window of 8-bit reference pixels over a valid/ready input. In average mode, the 64 current destination pixels follow the window on the same input. The block returns 64 filtered pixels in row order, one per cycle, and raises `done` together with the last one.

Only one offset may be nonzero. In that case a single 4-tap filter runs along that direction. When both offsets are nonzero, a vertical pass runs first. It writes signed 16-bit intermediates covering 11 columns by 8 rows into local storage. A horizontal pass then filters those intermediates. The full-pel case, where both offsets are zero, is outside this block, and a start request for it is ignored.

Top module: `qpel_interp`

## Requirements
- R1: After reset, `in_ready`, `out_valid` and `done` are low.
- R2: After an accepted `start`, `in_ready` is high until the window has been taken. The window is 121 bytes in row order. Window row i, column j holds the reference pixel at block row i-1, column j-1. In average mode, 64 destination bytes follow the window in row order. No output appears while loading.
- R3: Offset 2 (half-pel) applies the weights -1, 9, 9, -1 to the pixels at positions -1, 0, +1 and +2 along the filter direction.
- R4: Offset 1 applies the weights -4, 53, 18, -3 to the same four positions. Offset 3 applies the mirrored weights -3, 18, 53, -4.
- R5: With only the horizontal offset nonzero, the result is (sum + 8 - rnd) >>> 4 for offset 2. For offsets 1 and 3 it is (sum + 32 - rnd) >>> 6.
- R6: With only the vertical offset nonzero, the rounders become 7 + rnd for offset 2 and 31 + rnd for offsets 1 and 3. The shifts are the same as in R5.
- R7: With both offsets nonzero, the vertical pass produces signed 16-bit values for block columns -1..9 and rows 0..7. Each value is (sum + (1 << (k-1)) + rnd - 1) >>> k. Here k = (w(h) + w(v)) >> 1, with w = 1 for offset 2 and w = 5 for offsets 1 and 3.
- R8: The second pass applies the horizontal filter to the intermediates, then adds 64 - rnd and shifts arithmetically right by 7.
- R9: Every final pixel is clamped to 0..255.
- R10: In average mode, each output is (p + d + 1) >> 1, where p is the clamped pixel and d is the matching destination byte.
- R11: The 64 outputs appear on consecutive cycles in row order. `done` is high for exactly one cycle, in the cycle of the last output.
- R12: A `start` with both offsets zero is ignored: `in_ready`, `out_valid` and `done` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a block (sampled while idle) |
| hmode | input | 2 | Horizontal offset in quarter pels |
| vmode | input | 2 | Vertical offset in quarter pels |
| rnd | input | 1 | Rounding control |
| avg | input | 1 | 1: average with destination, 0: put |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block accepts an input byte |
| in_data | input | 8 | Window or destination byte |
| out_valid | output | 1 | Output pixel valid |
| out_data | output | 8 | Output pixel |
| done | output | 1 | Last pixel of the block |

## Verification
A wrong load counter or a misplaced window index corrupts pixels near the block edges. A wrong counter also shifts the whole output raster, so the first output pixel of the block already mismatches. A wrong rounder or shift changes about half of the pixels by one LSB. This is visible in the first output row for every mode pair that uses it. A corrupted intermediate in the two-pass path shows up in up to four horizontally adjacent outputs of the same row, about 89 cycles after loading ends. Sequencing faults show up within one block as a missing or extra `done`, or as an output count other than 64.

// File: rtl/qpel_interp.sv
module qpel_interp #(
  parameter int BLK = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] hmode,
  input  logic [1:0] vmode,
  input  logic       rnd,
  input  logic       avg,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       done
);
  localparam int WIN   = BLK + 3;
  localparam int WIN_N = WIN * WIN;
  localparam int DST_N = BLK * BLK;
  localparam int TMP_N = BLK * WIN;
  localparam int CW    = $clog2(WIN_N + DST_N + 1);
  localparam int PW    = $clog2(WIN + 1);
  localparam int WIW   = $clog2(WIN_N);
  localparam int TIW   = $clog2(TMP_N);
  localparam int DIW   = $clog2(DST_N);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_VERT, S_OUT} st_t;

  st_t st;
  logic [1:0] hm, vm;
  logic rb, av;
  logic [CW-1:0] cnt;
  logic [PW-1:0] row, col;

  logic [7:0]        win [WIN_N];
  logic [7:0]        dpx [DST_N];
  logic signed [15:0] tmp [TMP_N];

  wire two = (hm != 2'd0) && (vm != 2'd0);
  wire [CW-1:0] load_n = av ? CW'(WIN_N + DST_N) : CW'(WIN_N);
  assign in_ready = (st == S_LOAD);
  wire take      = in_ready && in_valid;
  wire last_load = take && (cnt == load_n - 1'b1);
  wire col_end   = (col == ((st == S_VERT) ? PW'(WIN - 1) : PW'(BLK - 1)));
  wire row_end   = (row == PW'(BLK - 1));

  function automatic logic signed [23:0] fir(input logic [1:0] m,
      input logic signed [23:0] a, input logic signed [23:0] b,
      input logic signed [23:0] c, input logic signed [23:0] d);
    case (m)
      2'd1:    return 24'(-4*a + 53*b + 18*c - 3*d);
      2'd3:    return 24'(-3*a + 18*b + 53*c - 4*d);
      default: return 24'(-a + 9*b + 9*c - d);
    endcase
  endfunction

  function automatic logic [3:0] wgt(input logic [1:0] m);
    return (m == 2'd2) ? 4'd1 : 4'd5;
  endfunction

  logic signed [23:0] tap [4];
  logic [1:0]         fmode;
  logic signed [23:0] rad;
  logic [3:0]         sh;
  logic [3:0]         vsh;
  logic signed [23:0] sum, val;
  logic [7:0]         pix;
  logic [8:0]         avg_sum;

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      if (st == S_VERT)
        tap[k] = {16'd0, win[WIW'((int'(row) + k) * WIN + int'(col))]};
      else if (two)
        tap[k] = 24'(tmp[TIW'(int'(row) * WIN + int'(col) + k)]);
      else if (vm != 2'd0)
        tap[k] = {16'd0, win[WIW'((int'(row) + k) * WIN + int'(col) + 1)]};
      else
        tap[k] = {16'd0, win[WIW'((int'(row) + 1) * WIN + int'(col) + k)]};
    end
  end

  assign vsh = 4'((5'(wgt(hm)) + 5'(wgt(vm))) >> 1);

  always_comb begin
    fmode = hm;
    if (st == S_VERT) begin
      fmode = vm;
      sh    = vsh;
      rad   = 24'((1 << (vsh - 4'd1)) + int'(rb) - 1);
    end else if (two) begin
      sh  = 4'd7;
      rad = 24'(64 - int'(rb));
    end else if (vm != 2'd0) begin
      fmode = vm;
      sh    = (vm == 2'd2) ? 4'd4 : 4'd6;
      rad   = (vm == 2'd2) ? 24'(7 + int'(rb)) : 24'(31 + int'(rb));
    end else begin
      sh  = (hm == 2'd2) ? 4'd4 : 4'd6;
      rad = (hm == 2'd2) ? 24'(8 - int'(rb)) : 24'(32 - int'(rb));
    end
  end

  assign sum = fir(fmode, tap[0], tap[1], tap[2], tap[3]);
  assign val = (sum + rad) >>> sh;
  assign pix = (val < 0) ? 8'd0 : (val > 24'sd255) ? 8'd255 : val[7:0];
  assign avg_sum = {1'b0, pix} + {1'b0, dpx[DIW'(int'(row) * BLK + int'(col))]} + 9'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      hm <= 2'd0; vm <= 2'd0; rb <= 1'b0; av <= 1'b0;
      cnt <= '0; row <= '0; col <= '0;
      out_valid <= 1'b0; out_data <= 8'd0; done <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      done      <= 1'b0;
      case (st)
        S_IDLE:
          if (start && (hmode != 2'd0 || vmode != 2'd0)) begin
            hm <= hmode; vm <= vmode; rb <= rnd; av <= avg;
            cnt <= '0;
            st  <= S_LOAD;
          end
        S_LOAD:
          if (take) begin
            cnt <= cnt + 1'b1;
            if (last_load) begin
              row <= '0; col <= '0;
              st  <= two ? S_VERT : S_OUT;
            end
          end
        default: begin
          if (st == S_OUT) begin
            out_valid <= 1'b1;
            out_data  <= av ? avg_sum[8:1] : pix;
          end
          if (col_end) begin
            col <= '0;
            if (row_end) begin
              row <= '0;
              if (st == S_OUT) begin
                done <= 1'b1;
                st   <= S_IDLE;
              end else begin
                st <= S_OUT;
              end
            end else begin
              row <= row + 1'b1;
            end
          end else begin
            col <= col + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      if (cnt < CW'(WIN_N)) win[WIW'(cnt)] <= in_data;
      else                  dpx[DIW'(cnt - CW'(WIN_N))] <= in_data;
    end
    if (st == S_VERT)
      tmp[TIW'(int'(row) * WIN + int'(col))] <= val[15:0];
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> !in_ready && !out_valid && !done);

  assert_no_output_loading_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid);

  assert_intermediate_fits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_VERT) |-> (val >= -24'sd32768 && val <= 24'sd32767));

  assert_done_with_pixel_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> out_valid);

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_zero_mode_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start && hmode == 2'd0 && vmode == 2'd0) |=> !in_ready);
endmodule

// File: tb/qpel_interp_test.sv
`timescale 1ns/1ps
module qpel_interp_test;
  localparam int W = 11;

  logic clk = 0, rst_n = 0;
  logic start = 0, rnd = 0, avg = 0, in_valid = 0;
  logic [1:0] hmode = 0, vmode = 0;
  logic [7:0] in_data = 0;
  logic in_ready, out_valid, done;
  logic [7:0] out_data;

  int checks = 0, errors = 0;
  int refw [W*W];
  int dstw [64];
  int expv [64];
  int tmpv [8*W];

  always #2.5 clk = ~clk;

  qpel_interp uut (.clk(clk), .rst_n(rst_n), .start(start), .hmode(hmode), .vmode(vmode),
    .rnd(rnd), .avg(avg), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .done(done));

  function automatic int fir(int m, int a, int b, int c, int d);
    if (m == 1) return -4*a + 53*b + 18*c - 3*d;
    if (m == 3) return -3*a + 18*b + 53*c - 4*d;
    return -a + 9*b + 9*c - d;
  endfunction

  function automatic int px(int y, int x);
    return refw[(y + 1) * W + x + 1];
  endfunction

  function automatic int clampv(int v);
    return v < 0 ? 0 : (v > 255 ? 255 : v);
  endfunction

  task automatic compute_expected(int h, int v, int r, int a);
    int sh, rd, p;
    for (int y = 0; y < 8; y++)
      for (int x = 0; x < 8; x++) begin
        if (h != 0 && v != 0) begin
          p = 0;
        end else if (v != 0) begin
          sh = (v == 2) ? 4 : 6;
          rd = (v == 2) ? 7 + r : 31 + r;
          p = clampv((fir(v, px(y-1,x), px(y,x), px(y+1,x), px(y+2,x)) + rd) >>> sh);
        end else begin
          sh = (h == 2) ? 4 : 6;
          rd = (h == 2) ? 8 - r : 32 - r;
          p = clampv((fir(h, px(y,x-1), px(y,x), px(y,x+1), px(y,x+2)) + rd) >>> sh);
        end
        expv[y*8+x] = p;
      end
    if (h != 0 && v != 0) begin
      sh = (((h == 2) ? 1 : 5) + ((v == 2) ? 1 : 5)) >> 1;
      rd = (1 << (sh - 1)) + r - 1;
      for (int y = 0; y < 8; y++)
        for (int c = 0; c < W; c++)
          tmpv[y*W+c] = (fir(v, px(y-1,c-1), px(y,c-1), px(y+1,c-1), px(y+2,c-1)) + rd) >>> sh;
      for (int y = 0; y < 8; y++)
        for (int x = 0; x < 8; x++)
          expv[y*8+x] = clampv((fir(h, tmpv[y*W+x], tmpv[y*W+x+1], tmpv[y*W+x+2],
                                   tmpv[y*W+x+3]) + 64 - r) >>> 7);
    end
    if (a != 0)
      for (int i = 0; i < 64; i++) expv[i] = (expv[i] + dstw[i] + 1) >> 1;
  endtask

  task automatic fill(int kind);
    for (int i = 0; i < W*W; i++)
      case (kind)
        1: refw[i] = 255;
        2: refw[i] = (((i / W) + (i % W)) % 2 == 0) ? 255 : 0;
        3: refw[i] = ((i % W) % 2 == 0) ? 0 : 255;
        default: refw[i] = int'($urandom_range(0, 255));
      endcase
    for (int i = 0; i < 64; i++) dstw[i] = int'($urandom_range(0, 255));
  endtask

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_block(int h, int v, int r, int a, string req);
    int idx, total, k, j, t;
    bit done_ok;
    compute_expected(h, v, r, a);
    total = W*W + (a != 0 ? 64 : 0);
    @(negedge clk);
    start = 1; hmode = 2'(h); vmode = 2'(v); rnd = r[0]; avg = a[0];
    @(negedge clk);
    start = 0;
    idx = 0; j = 0;
    while (idx < total && j < 1000) begin
      if (out_valid) check("R2", "output during load", 1, 0);
      in_valid = (j % 7 != 3);
      in_data  = 8'(idx < W*W ? refw[idx] : dstw[idx - W*W]);
      if (in_valid && in_ready) idx++;
      j++;
      @(negedge clk);
    end
    in_valid = 0;
    k = 0; t = 0; done_ok = 0;
    while (k < 64 && t < 400) begin
      if (out_valid) begin
        check(req, $sformatf("h=%0d v=%0d rnd=%0d avg=%0d pix%0d", h, v, r, a, k),
              int'(out_data), expv[k]);
        if (done) done_ok = (k == 63);
        k++;
      end else if (k != 0) begin
        check("R11", "gap in output stream", 0, 1);
      end
      t++;
      @(negedge clk);
    end
    check("R11", "pixel count", k, 64);
    check("R11", "done on last pixel", int'(done_ok), 1);
    check("R11", "done cleared", int'(done), 0);
    check("R2", "ready low after block", int'(in_ready), 0);
  endtask

  task automatic test_reset;
    check("R1", "in_ready at reset", int'(in_ready), 0);
    check("R1", "out_valid at reset", int'(out_valid), 0);
    check("R1", "done at reset", int'(done), 0);
  endtask

  task automatic test_hor_only;
    for (int h = 1; h < 4; h++)
      for (int r = 0; r < 2; r++) begin
        fill(0);
        run_block(h, 0, r, 0, h == 2 ? "R3_R5" : "R4_R5");
      end
  endtask

  task automatic test_ver_only;
    for (int v = 1; v < 4; v++)
      for (int r = 0; r < 2; r++) begin
        fill(0);
        run_block(0, v, r, 0, v == 2 ? "R3_R6" : "R4_R6");
      end
  endtask

  task automatic test_two_pass;
    for (int h = 1; h < 4; h++)
      for (int v = 1; v < 4; v++)
        for (int r = 0; r < 2; r++) begin
          fill(0);
          run_block(h, v, r, 0, "R7_R8");
        end
  endtask

  task automatic test_clamp;
    fill(2); run_block(2, 0, 0, 0, "R9");
    fill(3); run_block(1, 0, 1, 0, "R9");
    fill(3); run_block(3, 3, 0, 0, "R9");
    fill(2); run_block(0, 1, 1, 0, "R9");
    fill(1); run_block(2, 2, 1, 0, "R9");
  endtask

  task automatic test_avg;
    fill(0); run_block(1, 0, 0, 1, "R10");
    fill(0); run_block(0, 3, 1, 1, "R10");
    fill(0); run_block(2, 1, 0, 1, "R10");
    fill(3); run_block(3, 2, 1, 1, "R10");
  endtask

  task automatic test_zero_mode;
    @(negedge clk);
    start = 1; hmode = 0; vmode = 0;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < 5; i++) begin
      check("R12", "in_ready after zero-mode start", int'(in_ready), 0);
      check("R12", "out_valid after zero-mode start", int'(out_valid), 0);
      check("R12", "done after zero-mode start", int'(done), 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset;
    rst_n = 1;
    repeat (2) @(negedge clk);
    test_zero_mode;
    test_hor_only;
    test_ver_only;
    test_two_pass;
    test_clamp;
    test_avg;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule